// File: doc/BRIEF.md
# ISDN Terminal Activation Controller

This block runs the layer-1 activation procedure on the terminal side of an ISDN S/T line. Decoded 4-bit command codes arrive from the serial control channel together with a valid strobe. Three one-cycle recognition pulses report whether the line receiver has just identified INFO 0, INFO 2 or INFO 4. From these inputs the controller picks the signal the line transmitter sends and returns a 4-bit indication code to the controller.

Three forced states (reset, test, loop) can be entered from anywhere. The normal path runs through deactivated, power-up, pending activation, synchronized, activated, pending deactivation and unsynchronized. All outputs are decoded from a single registered state, so a change shows up just after the clock edge that samples its cause.

Top module: `te_act_ctrl`

## Requirements
- R1: A synchronous reset puts the block in the reset state. There tx_sel is 0 (INFO 0) and ci_ind is 4'h0. The remembered command code becomes 4'h1.
- R2: A command is acted on only when ci_valid is high and ci_code differs from the last code seen with ci_valid high. Every valid code updates that memory, including unknown codes such as 4'h5. A repeated code, an unknown code, or any code with ci_valid low leaves the outputs unchanged.
- R3: The codes 4'h1 (reset), 4'h2 (test) and 4'h3 (loop) force the matching state from any state. The outputs are tx_sel 0 / ci_ind 4'h0 for reset, tx_sel 2 (test pattern) / ci_ind 4'h2 for test, and tx_sel 3 (INFO 3) / ci_ind 4'h3 for loop.
- R4: In the three forced states, received INFO pulses and other commands have no effect. Only code 4'hF (deactivate) leaves them, and it goes to deactivated.
- R5: Deactivated sends INFO 0 with ci_ind 4'hF. From there, code 4'h0 leads to power-up (tx_sel 0, ci_ind 4'h7). Code 4'h8 or 4'h9 leads to pending activation.
- R6: In deactivated, power-up, pending activation and unsynchronized, an INFO 2 pulse leads to synchronized (tx_sel 3, ci_ind 4'h8). An INFO 4 pulse leads to activated (tx_sel 3, ci_ind 4'hC). INFO 4 wins when both pulses arrive together.
- R7: Pending activation sends INFO 1 (tx_sel 1) with ci_ind 4'h4. Code 4'h8 or 4'h9 moves power-up to pending activation. Code 4'hF returns both power-up and pending activation to deactivated.
- R8: An INFO 0 pulse in synchronized or activated, with no INFO 2 or INFO 4 pulse in the same cycle, leads to unsynchronized (tx_sel 0, ci_ind 4'hA). Code 4'hF moves unsynchronized to deactivated.
- R9: In synchronized or activated, code 4'hF leads to pending deactivation (tx_sel 0, ci_ind 4'h6). INFO 0 moves pending deactivation to deactivated. INFO 2 moves activated to synchronized, and INFO 4 moves synchronized to activated.
- R10: When inputs arrive in the same cycle, a forced-state command wins over a received INFO pulse, and a received INFO pulse wins over any other command.
- R11: Every output change appears after the first rising clock edge at which its cause is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ci_valid | input | 1 | Command code strobe |
| ci_code | input | 4 | Command code from the control channel |
| rx_info0 | input | 1 | INFO 0 recognised on the line (pulse) |
| rx_info2 | input | 1 | INFO 2 recognised on the line (pulse) |
| rx_info4 | input | 1 | INFO 4 recognised on the line (pulse) |
| tx_sel | output | 2 | Transmit signal: 0 INFO 0, 1 INFO 1, 2 test pattern, 3 INFO 3 |
| ci_ind | output | 4 | Indication code returned to the controller |

## Verification
A fresh command and a line recognition pulse can land on the same clock edge, and so can a forced-state command and a loss-of-signal pulse. The bench drives both combinations in a single cycle. It drives an activation command together with INFO 2 while the block is deactivated, and a test command together with INFO 0 while it is synchronized. It then compares the state reported on tx_sel and ci_ind after that edge with the priority order: forced command first, received signal second, other commands last.

// File: rtl/te_act_pkg.sv
package te_act_pkg;

    localparam int CI_W = 4;
    localparam int TX_W = 2;

    // command codes
    localparam logic [CI_W-1:0] CMD_TIMING = 4'h0;
    localparam logic [CI_W-1:0] CMD_RESET  = 4'h1;
    localparam logic [CI_W-1:0] CMD_TEST   = 4'h2;
    localparam logic [CI_W-1:0] CMD_LOOP   = 4'h3;
    localparam logic [CI_W-1:0] CMD_ACT8   = 4'h8;
    localparam logic [CI_W-1:0] CMD_ACT10  = 4'h9;
    localparam logic [CI_W-1:0] CMD_DEACT  = 4'hF;

    // indication codes
    localparam logic [CI_W-1:0] IND_RESET  = 4'h0;
    localparam logic [CI_W-1:0] IND_TEST   = 4'h2;
    localparam logic [CI_W-1:0] IND_LOOP   = 4'h3;
    localparam logic [CI_W-1:0] IND_PACT   = 4'h4;
    localparam logic [CI_W-1:0] IND_PDEACT = 4'h6;
    localparam logic [CI_W-1:0] IND_PWRUP  = 4'h7;
    localparam logic [CI_W-1:0] IND_SYNC   = 4'h8;
    localparam logic [CI_W-1:0] IND_UNSYNC = 4'hA;
    localparam logic [CI_W-1:0] IND_ACTV   = 4'hC;
    localparam logic [CI_W-1:0] IND_DEACT  = 4'hF;

    typedef enum logic [3:0] {
        S_RESET, S_TEST, S_LOOP, S_DEACT, S_PWRUP,
        S_PACT, S_SYNC, S_ACTV, S_PDEACT, S_UNSYNC
    } act_state_e;

    typedef enum logic [TX_W-1:0] {
        TX_INFO0 = 2'd0,
        TX_INFO1 = 2'd1,
        TX_TEST  = 2'd2,
        TX_INFO3 = 2'd3
    } tx_sel_e;

    typedef enum logic [2:0] {
        K_NONE, K_RESET, K_TEST, K_LOOP, K_TIMING, K_ACT, K_DEACT
    } cmd_kind_e;

    typedef enum logic [1:0] {
        RX_NONE, RX_I0, RX_I2, RX_I4
    } rx_kind_e;

    typedef struct packed {
        act_state_e st;
    } ctrl_state_t;

    typedef struct packed {
        logic [CI_W-1:0] last;
    } filt_state_t;

endpackage

// File: rtl/te_ci_filter.sv
module te_ci_filter
    import te_act_pkg::*;
#(
    parameter int W = CI_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid,
    input  logic [W-1:0] code,
    output logic         fresh,
    output cmd_kind_e    kind
);

    filt_state_t f_d, f_q;

    always_comb begin
        f_d   = f_q;
        fresh = valid && (code != f_q.last);
        if (valid) begin
            f_d.last = code;
        end
        kind = K_NONE;
        if (fresh) begin
            unique case (code)
                CMD_RESET:           kind = K_RESET;
                CMD_TEST:            kind = K_TEST;
                CMD_LOOP:            kind = K_LOOP;
                CMD_TIMING:          kind = K_TIMING;
                CMD_ACT8, CMD_ACT10: kind = K_ACT;
                CMD_DEACT:           kind = K_DEACT;
                default:             kind = K_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q.last <= CMD_RESET;
        end else begin
            f_q <= f_d;
        end
    end

endmodule

// File: rtl/te_rx_prio.sv
module te_rx_prio
    import te_act_pkg::*;
(
    input  logic     info0,
    input  logic     info2,
    input  logic     info4,
    output rx_kind_e rx
);

    always_comb begin
        if (info4) begin
            rx = RX_I4;
        end else if (info2) begin
            rx = RX_I2;
        end else if (info0) begin
            rx = RX_I0;
        end else begin
            rx = RX_NONE;
        end
    end

endmodule

// File: rtl/te_act_next.sv
module te_act_next
    import te_act_pkg::*;
(
    input  act_state_e cur,
    input  cmd_kind_e  kind,
    input  rx_kind_e   rx,
    output act_state_e nxt
);

    always_comb begin
        nxt = cur;
        if (kind == K_RESET) begin
            nxt = S_RESET;
        end else if (kind == K_TEST) begin
            nxt = S_TEST;
        end else if (kind == K_LOOP) begin
            nxt = S_LOOP;
        end else begin
            unique case (cur)
                S_RESET, S_TEST, S_LOOP: begin
                    if (kind == K_DEACT) nxt = S_DEACT;
                end
                S_DEACT: begin
                    if (rx == RX_I4)           nxt = S_ACTV;
                    else if (rx == RX_I2)      nxt = S_SYNC;
                    else if (kind == K_TIMING) nxt = S_PWRUP;
                    else if (kind == K_ACT)    nxt = S_PACT;
                end
                S_PWRUP: begin
                    if (rx == RX_I4)          nxt = S_ACTV;
                    else if (rx == RX_I2)     nxt = S_SYNC;
                    else if (kind == K_ACT)   nxt = S_PACT;
                    else if (kind == K_DEACT) nxt = S_DEACT;
                end
                S_PACT: begin
                    if (rx == RX_I4)          nxt = S_ACTV;
                    else if (rx == RX_I2)     nxt = S_SYNC;
                    else if (kind == K_DEACT) nxt = S_DEACT;
                end
                S_SYNC: begin
                    if (rx == RX_I4)          nxt = S_ACTV;
                    else if (rx == RX_I0)     nxt = S_UNSYNC;
                    else if (kind == K_DEACT) nxt = S_PDEACT;
                end
                S_ACTV: begin
                    if (rx == RX_I2)          nxt = S_SYNC;
                    else if (rx == RX_I0)     nxt = S_UNSYNC;
                    else if (kind == K_DEACT) nxt = S_PDEACT;
                end
                S_PDEACT: begin
                    if (rx == RX_I0) nxt = S_DEACT;
                end
                S_UNSYNC: begin
                    if (rx == RX_I4)          nxt = S_ACTV;
                    else if (rx == RX_I2)     nxt = S_SYNC;
                    else if (kind == K_DEACT) nxt = S_DEACT;
                end
                default: nxt = S_RESET;
            endcase
        end
    end

endmodule

// File: rtl/te_act_outmap.sv
module te_act_outmap
    import te_act_pkg::*;
#(
    parameter int W  = CI_W,
    parameter int TW = TX_W
) (
    input  act_state_e    st,
    output logic [TW-1:0] tx,
    output logic [W-1:0]  ind
);

    always_comb begin
        tx  = TX_INFO0;
        ind = IND_RESET;
        unique case (st)
            S_RESET:  begin tx = TX_INFO0; ind = IND_RESET;  end
            S_TEST:   begin tx = TX_TEST;  ind = IND_TEST;   end
            S_LOOP:   begin tx = TX_INFO3; ind = IND_LOOP;   end
            S_DEACT:  begin tx = TX_INFO0; ind = IND_DEACT;  end
            S_PWRUP:  begin tx = TX_INFO0; ind = IND_PWRUP;  end
            S_PACT:   begin tx = TX_INFO1; ind = IND_PACT;   end
            S_SYNC:   begin tx = TX_INFO3; ind = IND_SYNC;   end
            S_ACTV:   begin tx = TX_INFO3; ind = IND_ACTV;   end
            S_PDEACT: begin tx = TX_INFO0; ind = IND_PDEACT; end
            S_UNSYNC: begin tx = TX_INFO0; ind = IND_UNSYNC; end
            default:  begin tx = TX_INFO0; ind = IND_RESET;  end
        endcase
    end

endmodule

// File: rtl/te_act_ctrl.sv
module te_act_ctrl
    import te_act_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ci_valid,
    input  logic [CI_W-1:0] ci_code,
    input  logic            rx_info0,
    input  logic            rx_info2,
    input  logic            rx_info4,
    output logic [TX_W-1:0] tx_sel,
    output logic [CI_W-1:0] ci_ind
);

    logic        cmd_fresh;
    cmd_kind_e   cmd_kind;
    rx_kind_e    rx_kind;
    act_state_e  st_next;
    ctrl_state_t ctl_d, ctl_q;

    te_ci_filter #(.W(CI_W)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .valid (ci_valid),
        .code  (ci_code),
        .fresh (cmd_fresh),
        .kind  (cmd_kind)
    );

    te_rx_prio u_rx (
        .info0 (rx_info0),
        .info2 (rx_info2),
        .info4 (rx_info4),
        .rx    (rx_kind)
    );

    te_act_next u_next (
        .cur  (ctl_q.st),
        .kind (cmd_kind),
        .rx   (rx_kind),
        .nxt  (st_next)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.st = st_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st <= S_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    te_act_outmap #(.W(CI_W), .TW(TX_W)) u_out (
        .st  (ctl_q.st),
        .tx  (tx_sel),
        .ind (ci_ind)
    );

endmodule

// File: rtl/te_act_chk.sv
module te_act_chk
    import te_act_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ci_valid,
    input logic [CI_W-1:0] ci_code,
    input logic            rx_info0,
    input logic            rx_info2,
    input logic            rx_info4,
    input logic            cmd_fresh,
    input logic [TX_W-1:0] tx_sel,
    input logic [CI_W-1:0] ci_ind
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ci_ind == IND_RESET && tx_sel == TX_INFO0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ci_valid && !rx_info0 && !rx_info2 && !rx_info4) |=> $stable(ci_ind));

    // R3
    test_force_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_fresh && ci_code == CMD_TEST) |=> (ci_ind == IND_TEST && tx_sel == TX_TEST));

    // R4
    forced_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ((ci_ind == IND_RESET || ci_ind == IND_TEST || ci_ind == IND_LOOP)
         && cmd_fresh && ci_code == CMD_DEACT) |=> (ci_ind == IND_DEACT));

    // R8
    loss_unsync_chk: assert property (@(posedge clk) disable iff (rst)
        ((ci_ind == IND_ACTV || ci_ind == IND_SYNC) && rx_info0 && !rx_info2
         && !rx_info4 && !cmd_fresh) |=> (ci_ind == IND_UNSYNC));

endmodule

bind te_act_ctrl te_act_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ci_valid  (ci_valid),
    .ci_code   (ci_code),
    .rx_info0  (rx_info0),
    .rx_info2  (rx_info2),
    .rx_info4  (rx_info4),
    .cmd_fresh (cmd_fresh),
    .tx_sel    (tx_sel),
    .ci_ind    (ci_ind)
);

// File: tb/sim_te_act_ctrl.sv
`timescale 1ns/1ps
module sim_te_act_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ci_valid = 1'b0;
    logic [3:0] ci_code = 4'h0;
    logic       rx_info0 = 1'b0;
    logic       rx_info2 = 1'b0;
    logic       rx_info4 = 1'b0;
    logic [1:0] tx_sel;
    logic [3:0] ci_ind;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [1:0] tx;
        logic [3:0] ind;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    te_act_ctrl u0 (
        .clk      (clk),
        .rst      (rst),
        .ci_valid (ci_valid),
        .ci_code  (ci_code),
        .rx_info0 (rx_info0),
        .rx_info2 (rx_info2),
        .rx_info4 (rx_info4),
        .tx_sel   (tx_sel),
        .ci_ind   (ci_ind)
    );

    // driver: apply one cycle of stimulus, queue what must show after the edge
    task automatic step(input logic v, input logic [3:0] c,
                        input logic i0, input logic i2, input logic i4,
                        input logic [1:0] etx, input logic [3:0] eind,
                        input string req);
        @(negedge clk);
        ci_valid = v; ci_code = c;
        rx_info0 = i0; rx_info2 = i2; rx_info4 = i4;
        @(posedge clk);
        #1;
        ci_valid = 1'b0; rx_info0 = 1'b0; rx_info2 = 1'b0; rx_info4 = 1'b0;
        sb.push_back('{etx, eind, req});
    endtask

    task automatic cmd(input logic [3:0] c, input logic [1:0] etx,
                       input logic [3:0] eind, input string req);
        step(1'b1, c, 1'b0, 1'b0, 1'b0, etx, eind, req);
    endtask

    task automatic rx(input logic i0, input logic i2, input logic i4,
                      input logic [1:0] etx, input logic [3:0] eind, input string req);
        step(1'b0, ci_code, i0, i2, i4, etx, eind, req);
    endtask

    // monitor: compare outputs away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (tx_sel !== e.tx || ci_ind !== e.ind) begin
                    n_bad++;
                    $display("FAIL %s: tx_sel=%0d ci_ind=%h expected tx_sel=%0d ci_ind=%h",
                             e.req, tx_sel, ci_ind, e.tx, e.ind);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rx(1'b0, 1'b0, 1'b0, 2'd0, 4'h0, "R1 reset state");
        rx(1'b0, 1'b0, 1'b1, 2'd0, 4'h0, "R4 info4 ignored in reset");
        cmd(4'h8, 2'd0, 4'h0, "R4 act ignored in reset");
        cmd(4'hF, 2'd0, 4'hF, "R4 deact leaves reset");
        cmd(4'h0, 2'd0, 4'h7, "R5 R11 timing to power-up");
        cmd(4'hF, 2'd0, 4'hF, "R7 power-up to deact");
        cmd(4'h9, 2'd1, 4'h4, "R5 act10 to pending act");
        rx(1'b0, 1'b1, 1'b0, 2'd3, 4'h8, "R6 info2 to sync");
        rx(1'b0, 1'b0, 1'b1, 2'd3, 4'hC, "R9 sync info4 to active");
        rx(1'b1, 1'b0, 1'b0, 2'd0, 4'hA, "R8 info0 to unsync");
        cmd(4'hF, 2'd0, 4'hF, "R8 unsync deact");
        rx(1'b0, 1'b0, 1'b1, 2'd3, 4'hC, "R6 deact info4 to active");
        cmd(4'hF, 2'd3, 4'hC, "R2 repeated code ignored");
        cmd(4'h5, 2'd3, 4'hC, "R2 unknown code ignored");
        cmd(4'hF, 2'd0, 4'h6, "R9 deact to pending deact");
        rx(1'b1, 1'b0, 1'b0, 2'd0, 4'hF, "R9 pending deact info0");
        step(1'b1, 4'h8, 1'b0, 1'b1, 1'b0, 2'd3, 4'h8, "R10 info2 beats act");
        step(1'b0, 4'hF, 1'b0, 1'b0, 1'b0, 2'd3, 4'h8, "R2 strobe low ignored");
        step(1'b1, 4'h2, 1'b1, 1'b0, 1'b0, 2'd2, 4'h2, "R10 test beats info0");
        rx(1'b0, 1'b1, 1'b0, 2'd2, 4'h2, "R4 info2 ignored in test");
        cmd(4'h3, 2'd3, 4'h3, "R3 loop");
        cmd(4'h1, 2'd0, 4'h0, "R3 reset command");
        cmd(4'hF, 2'd0, 4'hF, "R4 deact from reset");
        rx(1'b0, 1'b1, 1'b1, 2'd3, 4'hC, "R6 info4 wins over info2");
        rx(1'b0, 1'b1, 1'b0, 2'd3, 4'h8, "R9 active info2 to sync");
        cmd(4'h8, 2'd3, 4'h8, "R9 act no effect in sync");
        cmd(4'hF, 2'd0, 4'h6, "R9 sync deact to pending deact");
        cmd(4'h3, 2'd3, 4'h3, "R3 loop from pending deact");
        // reset during operation
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        sb.push_back('{2'd0, 4'h0, "R1 reset mid-run"});
        @(negedge clk);
        rst = 1'b0;
        cmd(4'hF, 2'd0, 4'hF, "R4 deact after reset");
        cmd(4'h0, 2'd0, 4'h7, "R5 timing to power-up");
        cmd(4'h8, 2'd1, 4'h4, "R7 power-up act8 to pending act");
        cmd(4'hF, 2'd0, 4'hF, "R7 pending act deact");
        rx(1'b0, 1'b0, 1'b1, 2'd3, 4'hC, "R6 info4 to active");
        rx(1'b1, 1'b0, 1'b0, 2'd0, 4'hA, "R8 active loss");
        rx(1'b0, 1'b1, 1'b0, 2'd3, 4'h8, "R6 unsync info2 to sync");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule